// File: doc/BRIEF.md
# Sequential Prefetching Read Unit

This unit connects a stream of single-word read requests to a memory read port that can deliver bursts. It assumes every request asks for the word directly after the previous one. Because of that guess, it fetches whole bursts ahead of demand into a small data FIFO. A request that matches the guess is answered straight from the FIFO head.

When a request breaks the sequence, the unit empties the FIFO and marks every beat still owed by the memory as stale. It then restarts fetching at the new address. Stale beats are absorbed as they arrive and never reach the requester. The unit answers requests one at a time and in the order they arrive. The requester sees a discontinuity only as extra latency.

Top module: `seq_prefetch_reader`

## Requirements
- R1: After reset, `rsp_valid` and `mem_req_valid` are 0 and `req_ready` is 1. No burst is requested before the first request is accepted.
- R2: The first accepted request after reset counts as a break in the sequence. The first burst after it starts at the request's address, and `mem_req_len` carries the burst size as a plain word count (BURST, default 8).
- R3: Every accepted request gets exactly one response. Responses come in request order, and each `rsp_data` equals the memory word at the requested address.
- R4: A burst is requested only when the FIFO plus the beats still owed to it can take the whole burst. While the requester stalls, prefetch stops after DEPTH/BURST bursts (2 by default), and each burst starts BURST words after the previous one.
- R5: Within a contiguous run, burst addresses keep rising by BURST with no refetch. A request whose word is already buffered has `rsp_valid` high in the cycle right after it is accepted.
- R6: A request whose address is not the previous address plus one empties the FIFO, so `rsp_valid` is low in the next cycle. A burst then starts at the new address, and beats from bursts issued earlier are never delivered.
- R7: A response held by a low `rsp_ready` keeps `rsp_valid` high with unchanged data. A burst request held by a low `mem_req_ready` keeps `mem_req_valid` high with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | AW | Word address of the request |
| rsp_valid | output | 1 | Response data present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DW | Word returned for the oldest open request |
| mem_req_valid | output | 1 | Burst read command present |
| mem_req_ready | input | 1 | Memory accepts the burst command |
| mem_req_addr | output | AW | First word address of the burst |
| mem_req_len | output | $clog2(BURST+1) | Number of words in the burst |
| mem_rd_valid | input | 1 | One read-data beat present |
| mem_rd_data | input | DW | Read-data beat, delivered in command order |

## Verification
Faults in the block show up at the ports in three ways:
- A wrong predicted address or a missed flush shows up as a wrong `rsp_data` on the very response after the break.
- A miscounted stale-beat total shows up later, and only when beats are still in flight at the break. Old words then come out in place of new ones, or the unit hangs waiting for beats that never arrive.
- A credit error shows up as too many or too few bursts while the requester stalls, or as a FIFO overflow.

The tests therefore jump while the memory is slow and many beats are owed, and compare every word against the memory model.

// File: rtl/spr_pkg.sv
package spr_pkg;
    localparam int unsigned DEF_AW    = 32;
    localparam int unsigned DEF_DW    = 32;
    localparam int unsigned DEF_DEPTH = 16;
    localparam int unsigned DEF_BURST = 8;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_HOLD = 1'b1
    } cmd_state_e;
endpackage

// File: rtl/spr_fifo.sv
module spr_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [DW-1:0] store_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push) s_d.wr = s_q.wr + PTR_W'(1);
            if (pop)  s_d.rd = s_q.rd + PTR_W'(1);
            s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) store_q[s_q.wr] <= push_data;
    end

    assign head  = store_q[s_q.rd];
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
endmodule

// File: rtl/spr_fetch_ctl.sv
module spr_fetch_ctl
    import spr_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned BURST = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned OUT_W = $clog2(2 * DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic [AW-1:0]    restart_addr,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             mem_req_ready,
    input  logic             mem_rd_valid,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    output logic             fifo_push
);
    typedef struct packed {
        cmd_state_e       cmd;
        logic [AW-1:0]    cmd_addr;
        logic [AW-1:0]    fetch_addr;
        logic [OUT_W-1:0] owed;
        logic [OUT_W-1:0] drop;
    } fetch_state_t;

    fetch_state_t s_d, s_q;
    logic [OUT_W-1:0] live;
    logic             room_ok, cap_ok, can_issue, dropping;

    always_comb begin
        s_d       = s_q;
        dropping  = (s_q.drop != '0);
        fifo_push = mem_rd_valid && !dropping && !restart;
        live      = s_q.owed - s_q.drop;
        room_ok   = (32'(fifo_count) + 32'(live) + BURST) <= DEPTH;
        cap_ok    = (32'(s_q.owed) + BURST) <= 2 * DEPTH;
        can_issue = active && !restart && (s_q.cmd == CMD_IDLE) && room_ok && cap_ok;

        if (mem_rd_valid)             s_d.owed = s_q.owed - OUT_W'(1);
        if (mem_rd_valid && dropping) s_d.drop = s_q.drop - OUT_W'(1);
        if (s_q.cmd == CMD_HOLD && mem_req_ready) s_d.cmd = CMD_IDLE;

        if (restart) begin
            s_d.drop       = s_d.owed;
            s_d.fetch_addr = restart_addr;
        end else if (can_issue) begin
            s_d.cmd        = CMD_HOLD;
            s_d.cmd_addr   = s_q.fetch_addr;
            s_d.fetch_addr = s_q.fetch_addr + AW'(BURST);
            s_d.owed       = s_d.owed + OUT_W'(BURST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmd <= CMD_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_valid = (s_q.cmd == CMD_HOLD);
    assign mem_req_addr  = s_q.cmd_addr;
endmodule

// File: rtl/seq_prefetch_reader.sv
module seq_prefetch_reader #(
    parameter int unsigned AW    = spr_pkg::DEF_AW,
    parameter int unsigned DW    = spr_pkg::DEF_DW,
    parameter int unsigned DEPTH = spr_pkg::DEF_DEPTH,
    parameter int unsigned BURST = spr_pkg::DEF_BURST,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned LEN_W = $clog2(BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [DW-1:0]    rsp_data,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    output logic [LEN_W-1:0] mem_req_len,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data
);
    typedef struct packed {
        logic          pend;
        logic          armed;
        logic [AW-1:0] pred;
    } track_state_t;

    track_state_t     s_d, s_q;
    logic             req_fire, rsp_fire, miss;
    logic             fifo_push, fifo_empty;
    logic [CNT_W-1:0] fifo_count;

    always_comb begin
        s_d       = s_q;
        rsp_valid = s_q.pend && !fifo_empty;
        rsp_fire  = rsp_valid && rsp_ready;
        req_ready = !s_q.pend || rsp_fire;
        req_fire  = req_valid && req_ready;
        miss      = req_fire && (!s_q.armed || (req_addr != s_q.pred));
        if (rsp_fire) s_d.pend = 1'b0;
        if (req_fire) begin
            s_d.pend  = 1'b1;
            s_d.armed = 1'b1;
            s_d.pred  = req_addr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    spr_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (miss),
        .push      (fifo_push),
        .push_data (mem_rd_data),
        .pop       (rsp_fire),
        .head      (rsp_data),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    spr_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .BURST(BURST)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (s_q.armed),
        .restart       (miss),
        .restart_addr  (req_addr),
        .fifo_count    (fifo_count),
        .mem_req_ready (mem_req_ready),
        .mem_rd_valid  (mem_rd_valid),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .fifo_push     (fifo_push)
    );

    assign mem_req_len = LEN_W'(BURST);
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_fire,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [DW-1:0]    rsp_data,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             miss,
    input logic             fifo_push,
    input logic [CNT_W-1:0] fifo_count
);
    logic [1:0] open_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            seen_q <= 1'b0;
        end else begin
            open_q <= open_q + 2'(req_fire) - 2'(rsp_valid && rsp_ready);
            if (req_fire) seen_q <= 1'b1;
        end
    end

    // R1
    quiet_until_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> seen_q);

    // R3
    rsp_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (open_q == 2'd1));

    // R3
    single_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q <= 2'd1);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (32'(fifo_count) < DEPTH));

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !rsp_valid);

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind seq_prefetch_reader spr_checker #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_spr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .miss          (miss),
    .fifo_push     (fifo_push),
    .fifo_count    (fifo_count)
);

// File: tb/seq_prefetch_reader_bench.sv
module seq_prefetch_reader_bench;
    localparam int unsigned AW = 32, DW = 32, DEPTH = 16, BURST = 8;
    localparam int unsigned LEN_W = $clog2(BURST + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [AW-1:0]    req_addr = '0;
    logic             rsp_valid;
    logic             rsp_ready = 1'b0;
    logic [DW-1:0]    rsp_data;
    logic             mem_req_valid;
    logic             mem_req_ready = 1'b0;
    logic [AW-1:0]    mem_req_addr;
    logic [LEN_W-1:0] mem_req_len;
    logic             mem_rd_valid = 1'b0;
    logic [DW-1:0]    mem_rd_data = '0;

    seq_prefetch_reader #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BURST(BURST)) u_seq_prefetch_reader (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .rsp_valid, .rsp_ready, .rsp_data,
        .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_len, .mem_rd_valid, .mem_rd_data
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    int rr_mode = 1;       // 0 hold, 1 always ready, 2 random
    int stall_on = 0;
    int mem_lat = 4;
    longint cyc = 0;
    logic [AW-1:0] burst_log[$];
    logic [LEN_W-1:0] first_len = '0;
    logic [AW-1:0] q_addr[$];
    longint q_due[$];
    logic [AW-1:0] exp_q[$];
    int req_count = 0, rsp_count = 0;
    logic hold_prev = 1'b0;
    logic [AW-1:0] hold_addr = '0;

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // memory model, rsp_ready driver and watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R3 watchdog", 32'(cyc), 32'd150000);
            finish_run();
        end
        if (!rst_n) begin
            mem_rd_valid  <= 1'b0;
            mem_req_ready <= 1'b0;
            q_addr.delete();
            q_due.delete();
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                if (burst_log.size() == 0) first_len = mem_req_len;
                burst_log.push_back(mem_req_addr);
                for (int i = 0; i < int'(mem_req_len); i++) begin
                    q_addr.push_back(mem_req_addr + AW'(i));
                    q_due.push_back(cyc + longint'(mem_lat) + longint'(i));
                end
            end
            if (q_addr.size() > 0 && q_due[0] <= cyc) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem_word(q_addr.pop_front());
                void'(q_due.pop_front());
            end else begin
                mem_rd_valid <= 1'b0;
            end
            mem_req_ready <= (stall_on != 0) ? 1'($urandom_range(0, 1)) : 1'b1;
        end
        rsp_ready <= (rr_mode == 0) ? 1'b0 : (rr_mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
    end

    // response and handshake monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && rsp_ready) begin
                rsp_count++;
                if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", rsp_data, 32'h0);
                else begin
                    logic [AW-1:0] a;
                    a = exp_q.pop_front();
                    check(rsp_data == mem_word(a), "R3 response data", rsp_data, mem_word(a));
                end
            end
            if (req_valid && req_ready) begin
                exp_q.push_back(req_addr);
                req_count++;
            end
            if (hold_prev)
                check(mem_req_valid && (mem_req_addr == hold_addr), "R7 burst command hold",
                      mem_req_addr, hold_addr);
            hold_prev = mem_req_valid && !mem_req_ready;
            hold_addr = mem_req_addr;
        end
    end

    // call right after a posedge (+1); returns at the acceptance edge +1
    task automatic send_req(logic [AW-1:0] a);
        req_valid = 1'b1;
        req_addr  = a;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
    endtask

    task automatic req_idle();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && exp_q.size() > 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R3 all answered", 32'(exp_q.size()), 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
        repeat (10) @(negedge clk);
        check(burst_log.size() == 0, "R1 no burst before request", 32'(burst_log.size()), 32'd0);
        @(posedge clk); #1;
    endtask

    task automatic t_fill();
        rr_mode = 0; mem_lat = 6; stall_on = 0;
        @(posedge clk); #1;
        send_req(32'd100);
        req_idle();
        repeat (80) @(negedge clk);
        check(burst_log.size() == 2, "R4 bursts while stalled", 32'(burst_log.size()), 32'd2);
        check(burst_log[0] == 32'd100, "R2 first burst address", burst_log[0], 32'd100);
        check(first_len == LEN_W'(BURST), "R2 burst length", 32'(first_len), BURST);
        check(burst_log[1] == 32'd108, "R4 second burst address", burst_log[1], 32'd108);
        check(rsp_valid && rsp_data == mem_word(32'd100), "R7 held response", rsp_data, mem_word(32'd100));
        @(negedge clk);
        check(rsp_valid && rsp_data == mem_word(32'd100), "R7 held response stable", rsp_data,
              mem_word(32'd100));
        rr_mode = 1;
        drain();
    endtask

    task automatic t_hit_latency();
        repeat (5) @(posedge clk);
        #1;
        send_req(32'd101);
        req_idle();
        @(negedge clk);
        check(rsp_valid == 1'b1, "R5 buffered hit next cycle", 32'(rsp_valid), 32'd1);
        drain();
    endtask

    task automatic t_seq_run();
        int start, base;
        start = burst_log.size();
        base  = rsp_count;
        rr_mode = 2; stall_on = 1; mem_lat = 5;
        for (int a = 102; a < 202; a++) send_req(32'(a));
        req_idle();
        drain();
        check(rsp_count - base == 100, "R3 sequential count", 32'(rsp_count - base), 32'd100);
        for (int i = (start > 0 ? start : 1); i < burst_log.size(); i++)
            check(burst_log[i] == burst_log[i-1] + AW'(BURST), "R5 contiguous bursts",
                  burst_log[i], burst_log[i-1] + AW'(BURST));
        rr_mode = 1; stall_on = 0;
    endtask

    task automatic t_jump();
        int start;
        bit found;
        mem_lat = 20;
        for (int a = 202; a < 206; a++) send_req(32'(a));
        start = burst_log.size();
        send_req(32'd5000);
        req_idle();
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 no data right after jump", 32'(rsp_valid), 32'd0);
        drain();
        found = 1'b0;
        for (int i = start; i < burst_log.size(); i++)
            if (burst_log[i] == 32'd5000) found = 1'b1;
        check(found, "R6 burst at new address", 32'(found), 32'd1);
        for (int a = 5001; a < 5012; a++) send_req(32'(a));
        send_req(32'd7);
        for (int a = 8; a < 12; a++) send_req(32'(a));
        req_idle();
        drain();
    endtask

    task automatic t_random();
        logic [AW-1:0] a;
        int base;
        base = rsp_count;
        rr_mode = 2; stall_on = 1;
        a = 32'd900;
        for (int i = 0; i < 300; i++) begin
            mem_lat = $urandom_range(1, 25);
            if ($urandom_range(0, 4) == 0) a = 32'($urandom_range(0, 1 << 20));
            else a = a + 32'd1;
            send_req(a);
            if ($urandom_range(0, 7) == 0) begin
                req_idle();
                repeat ($urandom_range(1, 30)) @(posedge clk);
                #1;
            end
        end
        req_idle();
        drain();
        check(rsp_count - base == 300, "R3 random count", 32'(rsp_count - base), 32'd300);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_hit_latency();
        t_seq_run();
        t_jump();
        t_random();
        repeat (100) @(negedge clk);
        check(!rsp_valid && req_count == rsp_count, "R3 nothing left open", 32'(rsp_count), 32'(req_count));
        finish_run();
    end
endmodule